// File: doc/BRIEF.md
# Multi-Speed Serial Clock Generator

This block makes the serial clock (SCL) for a two-wire bus master. It keeps a high-phase count and a low-phase count for each of three speed modes: standard, fast and high speed. A 2-bit speed field in a small control register picks which pair of counts shapes the waveform. The clock toggles only while the controller is enabled, a speed is selected and the protocol engine reports an active transfer. At all other times SCL rests high and the phase counter restarts.

The protocol engine receives two single-cycle strobes. One comes at the middle of each high phase, where it samples the data line. The other comes on the first cycle of each low phase, where it may change the data line. Software sets up the count registers while the controller is disabled. Writes made to them while it is enabled are dropped. Clock stretching by a target and spike filtering are not part of this block.

Top module: `scl_speed_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `scl` is 1, `sample_stb` and `drive_stb` are 0, the enable bit is 0 and the speed field is 0.
- R2: The control register sits at byte offset 0x00. Bit 0 is the controller enable. Bits 2:1 are the speed field: 1 selects standard, 2 selects fast and 3 selects high speed. With speed field 0, no clock is produced and `scl` stays 1 even when enabled. The control register can be written at any time, and a new speed takes effect at once.
- R3: For speed field value m (1 to 3), the high count is at byte offset 0x14 + 8*(m-1) and the low count 4 bytes above it. Only the lowest CNT_W bits of the write data are kept.
- R4: While running, `scl` is 1 for (high count + 1) cycles and then 0 for (low count + 1) cycles, and this repeats. The first running cycle is the first cycle of a high phase. A count of 0 gives a one-cycle phase.
- R5: The clock runs only on cycles where enable is 1, the speed field is nonzero and `xfer_active` is 1. On any other cycle `scl` is 1 in that same cycle, both strobes are 0, and the next running cycle starts a fresh high phase.
- R6: `sample_stb` is 1 for exactly one cycle per high phase: the cycle whose position within the phase (counting from 0) equals floor(high count / 2).
- R7: `drive_stb` is 1 for exactly one cycle per low phase, on its first cycle. The two strobes are never 1 in the same cycle.
- R8: A write to any count register while the enable bit reads 1 is dropped and leaves that register unchanged.
- R9: After reset the count pairs (high, low) are 0x75/0x7C for standard, 0x15/0x21 for fast and 0x07/0x0E for high speed.
- R10: A write to an offset that is neither the control register nor one of the six count offsets changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| xfer_active | input | 1 | Protocol engine has a transfer in progress |
| scl | output | 1 | Generated serial clock level |
| sample_stb | output | 1 | Mid-high-phase sampling strobe |
| drive_stb | output | 1 | Start-of-low-phase data change strobe |

## Verification
The assertions assume two things about the inputs. First, `xfer_active` and the register writes change only between clock edges. Second, each write lasts a single cycle. The assertions claim nothing about the waveform after the speed field changes in the middle of a phase, except that the strobes keep their phase relation. The stimulus drives every input one time unit after a rising edge and keeps writes one cycle long. It changes speed while running only in scenarios where the bench's own cycle model tracks the count that carries over.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      SPD_OFF  = 2'd0,
      SPD_STD  = 2'd1,
      SPD_FAST = 2'd2,
      SPD_HIGH = 2'd3
   } spd_e;

   localparam int NUM_SPEEDS  = 3;
   localparam int CTRL_OFS    = 'h00;
   localparam int CNT_BASE    = 'h14;
   localparam int SPEED_STEP  = 8;
   localparam int LOW_STEP    = 4;
   localparam int EN_BIT      = 0;
   localparam int SPD_LSB     = 1;

   function automatic int hi_ofs(input int idx);
      return CNT_BASE + SPEED_STEP * idx;
   endfunction

   function automatic int lo_ofs(input int idx);
      return CNT_BASE + SPEED_STEP * idx + LOW_STEP;
   endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
   import scl_gen_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter logic [NUM_SPEEDS-1:0][CNT_W-1:0] RST_HI = '0,
   parameter logic [NUM_SPEEDS-1:0][CNT_W-1:0] RST_LO = '0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ADDR_W-1:0]                  wr_addr,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic                               cfg_en,
   output spd_e                               cfg_spd,
   output logic [NUM_SPEEDS-1:0][CNT_W-1:0]   hi_q,
   output logic [NUM_SPEEDS-1:0][CNT_W-1:0]   lo_q
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   logic ctrl_hit;
   assign ctrl_hit = wr_en && (wr_addr == CTRL_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en  <= 1'b0;
         cfg_spd <= SPD_OFF;
      end else if (ctrl_hit) begin
         cfg_en  <= wr_data[EN_BIT];
         cfg_spd <= spd_e'(wr_data[SPD_LSB +: 2]);
      end
   end

   // counts are writable only while the controller is disabled
   for (genvar gi = 0; gi < NUM_SPEEDS; gi++) begin : g_speed
      localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(hi_ofs(gi));
      localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(lo_ofs(gi));
      logic hi_hit, lo_hit;
      assign hi_hit = wr_en && !cfg_en && (wr_addr == HI_A);
      assign lo_hit = wr_en && !cfg_en && (wr_addr == LO_A);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q[gi] <= RST_HI[gi];
            lo_q[gi] <= RST_LO[gi];
         end else begin
            if (hi_hit) hi_q[gi] <= wr_data[CNT_W-1:0];
            if (lo_hit) lo_q[gi] <= wr_data[CNT_W-1:0];
         end
      end
   end

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] hi_cnt,
   input  logic [CNT_W-1:0] lo_cnt,
   output logic             scl,
   output logic             sample_stb,
   output logic             drive_stb
);

   logic             in_low;
   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] limit;
   logic             at_end;

   assign limit  = in_low ? lo_cnt : hi_cnt;
   // >= lets a shortened count, after a speed change, end the phase at once
   assign at_end = (pos >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_low <= 1'b0;
         pos    <= '0;
      end else if (!run) begin
         in_low <= 1'b0;
         pos    <= '0;
      end else if (at_end) begin
         in_low <= !in_low;
         pos    <= '0;
      end else begin
         pos    <= pos + 1'b1;
      end
   end

   assign scl        = !(run && in_low);
   assign sample_stb = run && !in_low && (pos == (hi_cnt >> 1));
   assign drive_stb  = run &&  in_low && (pos == '0);

endmodule

// File: rtl/scl_speed_gen.sv
module scl_speed_gen
   import scl_gen_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int STD_HI  = 'h75,
   parameter int STD_LO  = 'h7C,
   parameter int FAST_HI = 'h15,
   parameter int FAST_LO = 'h21,
   parameter int HIGH_HI = 'h07,
   parameter int HIGH_LO = 'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              xfer_active,
   output logic              scl,
   output logic              sample_stb,
   output logic              drive_stb
);

   localparam logic [NUM_SPEEDS-1:0][CNT_W-1:0] RST_HI =
      {CNT_W'(HIGH_HI), CNT_W'(FAST_HI), CNT_W'(STD_HI)};
   localparam logic [NUM_SPEEDS-1:0][CNT_W-1:0] RST_LO =
      {CNT_W'(HIGH_LO), CNT_W'(FAST_LO), CNT_W'(STD_LO)};

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the count offsets");
   end

   logic                             cfg_en;
   spd_e                             cfg_spd;
   logic [NUM_SPEEDS-1:0][CNT_W-1:0] hi_all;
   logic [NUM_SPEEDS-1:0][CNT_W-1:0] lo_all;
   logic [CNT_W-1:0]                 hi_sel;
   logic [CNT_W-1:0]                 lo_sel;
   logic                             run;

   scl_cfg_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .RST_HI (RST_HI),
      .RST_LO (RST_LO)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg_en  (cfg_en),
      .cfg_spd (cfg_spd),
      .hi_q    (hi_all),
      .lo_q    (lo_all)
   );

   always_comb begin
      unique case (cfg_spd)
         SPD_STD:  begin hi_sel = hi_all[0]; lo_sel = lo_all[0]; end
         SPD_FAST: begin hi_sel = hi_all[1]; lo_sel = lo_all[1]; end
         SPD_HIGH: begin hi_sel = hi_all[2]; lo_sel = lo_all[2]; end
         default:  begin hi_sel = '0;        lo_sel = '0;        end
      endcase
   end

   assign run = cfg_en && (cfg_spd != SPD_OFF) && xfer_active;

   scl_phase_ctr #(
      .CNT_W (CNT_W)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .hi_cnt     (hi_sel),
      .lo_cnt     (lo_sel),
      .scl        (scl),
      .sample_stb (sample_stb),
      .drive_stb  (drive_stb)
   );

endmodule

// File: rtl/scl_speed_gen_chk.sv
module scl_speed_gen_chk #(
   parameter int NSPD  = 3,
   parameter int CNT_W = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cfg_en,
   input logic                         run,
   input logic [NSPD-1:0][CNT_W-1:0]   hi_all,
   input logic [NSPD-1:0][CNT_W-1:0]   lo_all,
   input logic                         scl,
   input logic                         sample_stb,
   input logic                         drive_stb
);

   // R5
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (scl && !sample_stb && !drive_stb));

   // R6
   sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> scl);

   // R7
   drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl) |-> drive_stb);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sample_stb, drive_stb}));

   // R8
   hi_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> $stable(hi_all));

   // R8
   lo_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> $stable(lo_all));

endmodule

bind scl_speed_gen scl_speed_gen_chk #(
   .NSPD  (scl_gen_pkg::NUM_SPEEDS),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_en     (cfg_en),
   .run        (run),
   .hi_all     (hi_all),
   .lo_all     (lo_all),
   .scl        (scl),
   .sample_stb (sample_stb),
   .drive_stb  (drive_stb)
);

// File: tb/scl_speed_gen_bench.sv
`timescale 1ns/1ps
module scl_speed_gen_bench;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 16;
   localparam int WDOG   = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              xfer_active = 1'b0;
   logic              scl, sample_stb, drive_stb;

   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;   // 250 MHz

   scl_speed_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_scl_speed_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .xfer_active(xfer_active),
      .scl(scl), .sample_stb(sample_stb), .drive_stb(drive_stb)
   );

   // ---------------- behavioural reference model ----------------
   bit m_en;
   int m_spd;
   int m_hi[4];
   int m_lo[4];
   bit m_low;
   int m_pos;

   function automatic bit m_run();
      return m_en && (m_spd != 0) && xfer_active;
   endfunction

   task automatic m_reset();
      m_en = 0; m_spd = 0; m_low = 0; m_pos = 0;
      // R9 reset counts
      m_hi[1] = 'h75; m_lo[1] = 'h7C;
      m_hi[2] = 'h15; m_lo[2] = 'h21;
      m_hi[3] = 'h07; m_lo[3] = 'h0E;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reset();
      end else begin
         bit old_en;
         old_en = m_en;
         if (!m_run()) begin
            m_low = 0; m_pos = 0;
         end else if (m_pos >= (m_low ? m_lo[m_spd] : m_hi[m_spd])) begin
            m_low = !m_low; m_pos = 0;
         end else begin
            m_pos++;
         end
         if (wr_en) begin
            if (wr_addr == 8'h00) begin
               m_en = wr_data[0]; m_spd = int'(wr_data[2:1]);
            end else if (!old_en) begin
               for (int m = 1; m <= 3; m++) begin
                  if (int'(wr_addr) == 'h14 + 8*(m-1)) m_hi[m] = int'(wr_data[CNT_W-1:0]);
                  if (int'(wr_addr) == 'h18 + 8*(m-1)) m_lo[m] = int'(wr_data[CNT_W-1:0]);
               end
            end
         end
      end
   end

   task automatic check_bit(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   task automatic check_int(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      bit r;
      bit e_scl, e_smp, e_drv;
      r     = m_run();
      e_scl = !(r && m_low);
      e_smp = r && !m_low && (m_pos == (m_hi[m_spd] >> 1));
      e_drv = r && m_low && (m_pos == 0);
      check_bit(cur_req, "scl", scl, e_scl);
      check_bit(cur_req, "sample_stb", sample_stb, e_smp);
      check_bit(cur_req, "drive_stb", drive_stb, e_drv);
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == WDOG) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic reg_wr(input int addr, input int data);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   // length of the next complete run of scl at level lvl, sampled on falling edges
   task automatic measure(input logic lvl, output int n);
      n = 0;
      do @(negedge clk); while (scl === lvl);
      do @(negedge clk); while (scl !== lvl);
      while (scl === lvl) begin n++; @(negedge clk); end
   endtask

   initial begin
      int n;
      m_reset();
      // R1 reset state
      cur_req = "R1";
      wait_cycles(4);
      @(negedge clk);
      check_bit("R1", "scl in reset", scl, 1'b1);
      check_bit("R1", "sample_stb in reset", sample_stb, 1'b0);
      check_bit("R1", "drive_stb in reset", drive_stb, 1'b0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1", "scl after reset", scl, 1'b1);

      // R9 / R4 standard defaults
      cur_req = "R9";
      xfer_active = 1'b1;
      reg_wr('h00, 32'b011);           // enable, standard
      measure(1'b1, n); check_int("R9", "standard high length", n, 'h75 + 1);
      measure(1'b0, n); check_int("R9", "standard low length", n, 'h7C + 1);
      // R2 switch to fast while running, then high speed
      cur_req = "R2";
      reg_wr('h00, 32'b101);
      wait_cycles(120);
      measure(1'b0, n); check_int("R2", "fast low length", n, 'h21 + 1);
      reg_wr('h00, 32'b111);
      measure(1'b1, n); check_int("R2", "high-speed high length", n, 'h07 + 1);
      wait_cycles(40);

      // R8 count write while enabled is dropped
      cur_req = "R8";
      reg_wr('h00, 32'b101);
      reg_wr('h1C, 2);
      reg_wr('h20, 2);
      measure(1'b1, n); check_int("R8", "fast high after locked write", n, 'h15 + 1);
      measure(1'b0, n); check_int("R8", "fast low after locked write", n, 'h21 + 1);

      // R5 transfer pause
      cur_req = "R5";
      wait_cycles(7);
      xfer_active = 1'b0;
      wait_cycles(10);
      @(negedge clk); check_bit("R5", "scl while paused", scl, 1'b1);
      #1 xfer_active = 1'b1;
      wait_cycles(60);

      // R2 speed 0 gives no clock
      cur_req = "R2";
      reg_wr('h00, 32'b001);
      n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (scl !== 1'b1 || sample_stb || drive_stb) n++;
      end
      check_int("R2", "activity cycles with speed 0", n, 0);

      // R3 / R4 / R6 / R7 custom counts written while disabled
      cur_req = "R3";
      reg_wr('h00, 0);
      reg_wr('h1C, 3);
      reg_wr('h20, 5);
      reg_wr('h24, 0);
      reg_wr('h28, 0);
      reg_wr('h14, 32'hFFFF_0001);     // upper bits dropped
      reg_wr('h18, 2);
      reg_wr('h00, 32'b101);
      cur_req = "R4";
      measure(1'b1, n); check_int("R4", "fast high length", n, 4);
      measure(1'b0, n); check_int("R4", "fast low length", n, 6);
      cur_req = "R6";
      n = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (sample_stb) n++; end
      check_int("R6", "sample strobes in 30 cycles (period 10)", n, 3);
      cur_req = "R7";
      reg_wr('h00, 32'b111);           // zero counts: toggle every cycle
      measure(1'b0, n); check_int("R7", "high-speed low length", n, 1);
      n = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (drive_stb) n++; end
      check_int("R7", "drive strobes in 20 cycles", n, 10);
      cur_req = "R3";
      reg_wr('h00, 32'b011);
      measure(1'b1, n); check_int("R3", "standard high after masked write", n, 2);
      measure(1'b0, n); check_int("R3", "standard low", n, 3);

      // R10 stray offsets
      cur_req = "R10";
      reg_wr('h00, 0);
      reg_wr('h30, 9);
      reg_wr('h16, 9);
      reg_wr('h00, 32'b011);
      measure(1'b1, n); check_int("R10", "standard high after stray writes", n, 2);
      measure(1'b0, n); check_int("R10", "standard low after stray writes", n, 3);
      wait_cycles(20);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule